// File: doc/BRIEF.md
# I2C Ten-Bit Address Slave Receiver

This block is the receive side of an I2C slave. It watches the bus for a START, takes the next two bytes as a ten-bit address and acknowledges them when they match its own address. After that it accepts write data from the master one byte at a time. SDA and SCL are driven through open-drain enables: an enable high pulls the line low. Both bus inputs are synchronised to the system clock before any edge is detected.

A host CPU reaches the block through four byte registers, selected by `reg_sel`:

| Select | Contents |
|---|---|
| 0 | Status. Bit 0: address matched. Bit 1: receive data full. Bit 2: STOP or RESTART seen. |
| 1 | Received data. |
| 2 | Control. Bit 0: interrupt enable. Bit 1: NAK request. Bits 3:2: own address bits 9:8. |
| 3 | Own address bits 7:0. |

Bits 0 and 2 of the status register clear when the host reads the status register. Bit 1 clears when the host reads the data register. While a received byte is still unread, the block holds SCL low after the acknowledge slot, so the master waits and the byte is never overwritten. Setting the NAK request makes the slave refuse the next data byte, which lets software end a transfer after one more byte.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset the status and control registers read 0, `irq` is low, and neither `sda_oe` nor `scl_oe` is asserted.
- R2: The first byte after a START is acknowledged only when it is 11110 followed by own address bits 9:8 and a R/W bit of 0. A header with other address bits, or with R/W = 1, is left unacknowledged.
- R3: A second address byte equal to own address bits 7:0 is acknowledged and sets status bit 0.
- R4: After either address byte fails to match, the slave acknowledges nothing and sets no status flag until the next START.
- R5: `irq` is high exactly when control bit 0 is set and at least one status bit is set.
- R6: A status register read clears status bits 0 and 2 and leaves bit 1 unchanged.
- R7: Each data byte received after a matched address is placed in the data register and sets status bit 1. Reading the data register clears status bit 1.
- R8: A data byte is acknowledged unless control bit 1 is set. In that case the byte gets a Not Acknowledge and control bit 1 clears itself.
- R9: A STOP or a repeated START that follows a matched address sets status bit 2. A STOP or repeated START while the slave is not addressed leaves bit 2 unchanged.
- R10: While status bit 1 is set after the acknowledge slot of a data byte, `scl_oe` holds SCL low with SDA released. SCL is let go once the data register is read.
- R11: SDA changes while SCL is low are taken as data bits, not as START or STOP, so any bit pattern is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| reg_sel | input | 2 | Host register select |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears flags on read) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is SCL being held low. It only occurs when the ack slot of a data byte ends while the previous byte is still unread. To check it, the bench's master model respects clock stretching and waits on the real line level. The host model reads the data register only after the byte's ack slot has closed. A NAK request is planted before the last byte of randomly sized transfers. Some transfers end with a repeated START instead of a STOP, so the flag setting of R9 is seen both after an addressed transfer and after an unaddressed one.

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int HI = AW - DW;
  localparam int BW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_LOW, S_DATA} stage_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_p, sda_p;
  stage_t        stage;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] shreg, data_q;
  logic          byte_done, in_ack, sda_drv, scl_hold, addressed;
  logic          addr_hit, rx_full, stop_hit, irq_en, nak_req;
  logic [AW-1:0] own;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;

  wire rd_stat = reg_rd && reg_sel == 2'd0;
  wire rd_data = reg_rd && reg_sel == 2'd1;
  wire hdr_ok = shreg[DW-1:HI+1] == 5'b11110 && shreg[HI:1] == own[AW-1:DW] && !shreg[0];
  wire low_ok = shreg == own[DW-1:0];

  assign sda_oe = sda_drv;
  assign scl_oe = scl_hold;
  assign irq = irq_en & (addr_hit | rx_full | stop_hit);

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {{(DW-3){1'b0}}, stop_hit, rx_full, addr_hit};
      2'd1:    reg_rdata = data_q;
      2'd2:    reg_rdata = {{(DW-HI-2){1'b0}}, own[AW-1:DW], nak_req, irq_en};
      default: reg_rdata = own[DW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;  sda_sy <= 2'b11;
      scl_p <= 1'b1;    sda_p <= 1'b1;
      stage <= S_IDLE;  bitcnt <= '0;
      shreg <= '0;      data_q <= '0;
      byte_done <= 1'b0; in_ack <= 1'b0;
      sda_drv <= 1'b0;  scl_hold <= 1'b0;
      addressed <= 1'b0; addr_hit <= 1'b0;
      rx_full <= 1'b0;  stop_hit <= 1'b0;
      irq_en <= 1'b0;   nak_req <= 1'b0;
      own <= '0;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_p <= scl_s;
      sda_p <= sda_s;

      if (rd_stat) begin
        addr_hit <= 1'b0;
        stop_hit <= 1'b0;
      end
      if (rd_data) rx_full <= 1'b0;
      if (!rx_full) scl_hold <= 1'b0;
      if (reg_wr && reg_sel == 2'd2) begin
        irq_en <= reg_wdata[0];
        nak_req <= reg_wdata[1];
        own[AW-1:DW] <= reg_wdata[HI+1:2];
      end
      if (reg_wr && reg_sel == 2'd3) own[DW-1:0] <= reg_wdata;

      if (start_c || stop_c) begin
        if (addressed) stop_hit <= 1'b1;
        addressed <= 1'b0;
        sda_drv <= 1'b0;
        scl_hold <= 1'b0;
        in_ack <= 1'b0;
        byte_done <= 1'b0;
        bitcnt <= '0;
        stage <= start_c ? S_HDR : S_IDLE;
      end else if (stage != S_IDLE) begin
        if (scl_rise && !in_ack) begin
          shreg <= {shreg[DW-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BW'(DW-1)) byte_done <= 1'b1;
        end else if (scl_fall && byte_done) begin
          byte_done <= 1'b0;
          case (stage)
            S_HDR:
              if (hdr_ok) begin
                in_ack <= 1'b1; sda_drv <= 1'b1; stage <= S_LOW;
              end else stage <= S_IDLE;
            S_LOW:
              if (low_ok) begin
                in_ack <= 1'b1; sda_drv <= 1'b1;
                addr_hit <= 1'b1; addressed <= 1'b1; stage <= S_DATA;
              end else stage <= S_IDLE;
            default: begin
              in_ack <= 1'b1;
              data_q <= shreg;
              rx_full <= 1'b1;
              sda_drv <= !nak_req;
              nak_req <= 1'b0;
            end
          endcase
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0;
          sda_drv <= 1'b0;
          bitcnt <= '0;
          if (stage == S_DATA && rx_full) scl_hold <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c10_slave_rx_chk.sv
module i2c10_slave_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       addr_hit,
  input logic       rx_full,
  input logic       nak_req
);
  assert_match_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit) |-> sda_oe);

  assert_rx_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !(reg_rd && reg_sel == 2'd1)) |=> rx_full);

  assert_nak_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nak_req) && !$past(reg_wr && reg_sel == 2'd2)) |-> !sda_oe);

  assert_hold_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> rx_full);

  assert_hold_sda_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !sda_oe);
endmodule

bind i2c10_slave_rx i2c10_slave_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .addr_hit(addr_hit), .rx_full(rx_full),
  .nak_req(nak_req)
);

// File: tb/i2c10_slave_rx_tb_top.sv
`timescale 1ns/1ps
module i2c10_slave_rx_tb_top;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [9:0] own;

  always #4 clk = ~clk;

  i2c10_slave_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] hdr_of(logic [9:0] a, bit rw);
    return {5'b11110, a[9:8], rw};
  endfunction

  function automatic logic [7:0] stat_of(bit m, bit f, bit s);
    return {5'b0, s, f, m};
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    do @(negedge clk); while (!scl_line);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); scl_up(); tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); scl_up(); tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); scl_up(); tick(2*Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); scl_up(); tick(Q);
    ack = !sda_line;
    tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic hrd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic hwr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic set_cfg(bit ien, bit nak);
    hwr(2'd3, own[7:0]);
    hwr(2'd2, {4'b0, own[9:8], nak, ien});
  endtask

  task automatic xfer(int n, bit use_nak, bit end_rs, bit ien);
    bit ack;
    logic [7:0] v, b;
    bus_start();
    send(hdr_of(own, 1'b0), ack); chk("R2 header ack", ack, 1);
    send(own[7:0], ack);          chk("R3 low byte ack", ack, 1);
    chk("R5 irq on match", irq, ien);
    hrd(2'd0, v); chk("R3 match flag", v, stat_of(1, 0, 0));
    hrd(2'd0, v); chk("R6 cleared by read", v, 0);
    chk("R5 irq idle", irq, 0);
    for (int j = 0; j < n; j++) begin
      bit last_nak;
      last_nak = use_nak && j == n - 1;
      if (last_nak) set_cfg(ien, 1'b1);
      b = (j == 0) ? 8'h5A ^ 8'($urandom) : 8'($urandom);
      send(b, ack); chk("R8 data ack", ack, !last_nak);
      tick(2); chk("R10 SCL held", scl_oe, 1);
      chk("R5 irq on data", irq, ien);
      hrd(2'd0, v); chk("R7 full flag", v, stat_of(0, 1, 0));
      hrd(2'd0, v); chk("R6 full kept", v, stat_of(0, 1, 0));
      hrd(2'd1, v); chk(j == 0 ? "R11 data bits" : "R7 data value", v, b);
      tick(3); chk("R10 SCL released", scl_oe, 0);
      hrd(2'd0, v); chk("R7 full cleared", v, 0);
      if (last_nak) begin
        hrd(2'd2, v); chk("R8 nak self clear", v[1], 0);
      end
    end
    if (end_rs) begin
      bus_start(); tick(2);
      hrd(2'd0, v); chk("R9 restart flag", v, stat_of(0, 0, 1));
      bus_stop();
      hrd(2'd0, v); chk("R9 unaddressed stop", v, 0);
    end else begin
      bus_stop();
      chk("R5 irq on stop", irq, ien);
      hrd(2'd0, v); chk("R9 stop flag", v, stat_of(0, 0, 1));
    end
  endtask

  initial begin
    bit ack;
    logic [7:0] v;
    void'($urandom(32'd4711));
    tick(4); rst_n = 1'b1; tick(2);
    chk("R1 irq", irq, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    hrd(2'd0, v); chk("R1 status", v, 0);
    hrd(2'd2, v); chk("R1 control", v, 0);

    own = 10'h2C7;
    set_cfg(1'b1, 1'b0);
    xfer(2, 1'b1, 1'b0, 1'b1);

    for (int t = 0; t < 6; t++) begin
      bit ien;
      own = 10'($urandom);
      ien = 1'($urandom);
      set_cfg(ien, 1'b0);
      xfer(1 + int'($urandom % 3), 1'($urandom), 1'($urandom), ien);
    end

    own = 10'h1A3;
    set_cfg(1'b1, 1'b0);
    bus_start();
    send(hdr_of(own ^ 10'h300, 1'b0), ack); chk("R2 wrong header nak", ack, 0);
    send(8'hA5, ack); chk("R4 ignored after header", ack, 0);
    hrd(2'd0, v); chk("R4 no flags", v, 0);
    bus_stop();
    hrd(2'd0, v); chk("R9 stop when unaddressed", v, 0);

    bus_start();
    send(hdr_of(own, 1'b1), ack); chk("R2 read header nak", ack, 0);
    bus_stop();

    bus_start();
    send(hdr_of(own, 1'b0), ack); chk("R2 header ack", ack, 1);
    send(own[7:0] ^ 8'h01, ack); chk("R4 low mismatch nak", ack, 0);
    send(8'h3C, ack); chk("R4 data ignored", ack, 0);
    chk("R4 no hold", scl_oe, 0);
    hrd(2'd0, v); chk("R4 status clear", v, 0);
    chk("R5 irq low", irq, 0);
    bus_stop();

    xfer(1, 1'b0, 1'b0, 1'b1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule